// File: doc/BRIEF.md
# BCD Real-Time Calendar with Two-Stage Prescaler

This block keeps wall-clock time and calendar date in packed BCD and advances them once per second. The one-second tick is obtained from the RTC-domain clock through two cascaded down-counters. A short asynchronous-style stage divides first, and a wider synchronous stage divides its output further. The calendar tracks seconds, minutes, hours, day of month, month, weekday and a two-digit year. Hours can run in either 24-hour or 12-hour (AM/PM) form.

Software sees five register words through a flat select/data port: time, date, control, status and prescaler. Time, date, control and prescaler may only be written after an initialization handshake. Software raises a request flag, and the block answers with an active flag a fixed number of clocks later. While the active flag is set, counting is frozen. Dropping the request restarts both dividers from their reload values.

Time and date reads come from shadow copies. A synchronization flag reports when those copies are valid again. It drops when software writes zero to it and when init mode ends. It returns a fixed number of clocks later, once the shadows have been refreshed.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset, time reads 0x00000000, date reads 0x00002101 (day 01, month 01, weekday 1, year 00), control reads 0, prescaler reads 0x007F00FF, and status settles to 0x20.
- R2: Register selects are 0 time, 1 date, 2 control, 3 status, 4 prescaler. Status bit 7 is the init request, written directly. Status bit 6 (init active) rises INIT_LAT clocks after the edge that stores the request. It falls on the first edge after the request is seen cleared.
- R3: Writes to time, date, control and prescaler take effect only while init active is set. At any other time they leave every readable value unchanged.
- R4: While init active is set, the calendar does not advance and tick_1hz stays low.
- R5: The prescaler word holds S in bits 14:0 and A in bits 22:16. tick_1hz pulses once every (A+1)*(S+1) clocks. Both dividers reload on the edge where init active falls, so the first tick follows that edge by exactly (A+1)*(S+1) clocks.
- R6: The time word holds BCD seconds in bits 6:0, minutes in 14:8 and hours in 21:16. Each tick adds one second with BCD digit carry. Seconds and minutes wrap 59 to 00. In 24-hour mode, hours wrap 23 to 00 and advance the date.
- R7: Control bit 6 set selects 12-hour mode, with time bit 22 as the PM flag. In this mode 11:59:59 becomes 12:00:00 with PM toggled, and 12:59:59 becomes 01:00:00. The date advances only on the PM-to-AM change.
- R8: The date word holds BCD day in bits 5:0, month in 12:8, weekday in 15:13 and year in 23:16. Day wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months. February ends at 29 when the year is divisible by 4 and at 28 otherwise.
- R9: Month wraps 12 to 01 and increments the year, and year wraps 99 to 00. Weekday (1 = Monday to 7 = Sunday) advances with each day and wraps 7 to 1.
- R10: Status bit 5 (sync) is cleared by a status write with bit 5 at 0 and on init exit. A write with bit 5 at 1 leaves it unchanged. It is set SYNC_LAT clocks after the clearing edge, outside init mode. Time and date reads return the refreshed shadow copies.
- R11: Status bit 4 is clear exactly when the live year field is 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | RTC-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Read data for rd_sel, combinational |
| tick_1hz | output | 1 | One-clock pulse at each calendar advance |

## Verification
The bench loads the calendar just before a boundary and lets exactly one tick pass. The boundaries covered are the end of February in leap and common years, 30-day and 31-day months, New Year's Eve of year 99, and the three 12-hour transitions. A design with a wrong month-length table or leap rule would land on 29 February in a common year or 31 April, and a missing PM toggle would leave 12-hour time on the wrong half-day. The bench also measures the cycle of the first tick after init exit, which exposes dividers that are not reloaded or that are off by one in their terminal count. It writes every protected register outside init mode and reads it back, to catch writes that leak through. It times the init and sync flags edge by edge, to catch handshakes that are a cycle early or late.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int REG_W = 32;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_TIME = 3'd0,
    SEL_DATE = 3'd1,
    SEL_CTRL = 3'd2,
    SEL_STAT = 3'd3,
    SEL_PRE  = 3'd4
  } reg_sel_e;

  // status and control bit positions (software decodes these)
  localparam int ST_REQ   = 7;
  localparam int ST_ACT   = 6;
  localparam int ST_SYNC  = 5;
  localparam int ST_INITS = 4;
  localparam int CTRL_FMT = 6;
  localparam int PRE_A_LSB = 16;

  typedef struct packed {
    logic       pm;
    logic [5:0] hr;
    logic [6:0] mn;
    logic [6:0] sc;
  } time_t;

  typedef struct packed {
    logic [7:0] yr;
    logic [2:0] wd;
    logic [4:0] mo;
    logic [5:0] dy;
  } date_t;

  typedef struct packed {
    logic  carry;
    time_t t;
  } time_step_t;

  localparam time_t RST_TIME = '{pm: 1'b0, hr: 6'h00, mn: 7'h00, sc: 7'h00};
  localparam date_t RST_DATE = '{yr: 8'h00, wd: 3'd1, mo: 5'h01, dy: 6'h01};

  // two-digit BCD increment, no wrap handling
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
  endfunction

  function automatic logic leap_year(input logic [7:0] yr);
    logic [6:0] b;
    b = bcd_to_bin(yr);
    return (b[1:0] == 2'b00);
  endfunction

  // last day of the month, BCD
  function automatic logic [5:0] month_len(input logic [4:0] mo, input logic [7:0] yr);
    logic [5:0] r;
    case (mo)
      5'h02:                     r = leap_year(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
      default:                   r = 6'h31;
    endcase
    return r;
  endfunction

  function automatic time_step_t time_step(input time_t t, input logic h12);
    time_step_t r;
    logic [7:0] tmp;
    r.t = t;
    r.carry = 1'b0;
    if (t.sc != 7'h59) begin
      tmp = bcd_inc({1'b0, t.sc});
      r.t.sc = tmp[6:0];
    end else begin
      r.t.sc = 7'h00;
      if (t.mn != 7'h59) begin
        tmp = bcd_inc({1'b0, t.mn});
        r.t.mn = tmp[6:0];
      end else begin
        r.t.mn = 7'h00;
        tmp = bcd_inc({2'b00, t.hr});
        if (!h12) begin
          if (t.hr == 6'h23) begin
            r.t.hr  = 6'h00;
            r.carry = 1'b1;
          end else begin
            r.t.hr = tmp[5:0];
          end
        end else begin
          if (t.hr == 6'h12) begin
            r.t.hr = 6'h01;
          end else if (t.hr == 6'h11) begin
            r.t.hr  = 6'h12;
            r.t.pm  = ~t.pm;
            r.carry = t.pm;
          end else begin
            r.t.hr = tmp[5:0];
          end
        end
      end
    end
    return r;
  endfunction

  function automatic date_t date_step(input date_t d);
    date_t r;
    logic [7:0] tmp;
    r = d;
    r.wd = (d.wd == 3'd7) ? 3'd1 : d.wd + 3'd1;
    if (d.dy != month_len(d.mo, d.yr)) begin
      tmp = bcd_inc({2'b00, d.dy});
      r.dy = tmp[5:0];
    end else begin
      r.dy = 6'h01;
      if (d.mo == 5'h12) begin
        r.mo = 5'h01;
        r.yr = (d.yr == 8'h99) ? 8'h00 : bcd_inc(d.yr);
      end else begin
        tmp = bcd_inc({3'b000, d.mo});
        r.mo = tmp[4:0];
      end
    end
    return r;
  endfunction

  function automatic logic [REG_W-1:0] time_to_word(input time_t t);
    return {9'b0, t.pm, t.hr, 1'b0, t.mn, 1'b0, t.sc};
  endfunction

  function automatic logic [REG_W-1:0] date_to_word(input date_t d);
    return {8'b0, d.yr, d.wd, d.mo, 2'b0, d.dy};
  endfunction

  function automatic time_t word_to_time(input logic [REG_W-1:0] w);
    time_t t;
    t.pm = w[22];
    t.hr = w[21:16];
    t.mn = w[14:8];
    t.sc = w[6:0];
    return t;
  endfunction

  function automatic date_t word_to_date(input logic [REG_W-1:0] w);
    date_t d;
    d.yr = w[23:16];
    d.wd = w[15:13];
    d.mo = w[12:8];
    d.dy = w[5:0];
    return d;
  endfunction

endpackage

// File: rtl/rtc_div_stage.sv
module rtc_div_stage #(
  parameter int W       = 7,
  parameter int RST_VAL = 127
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] reload,
  input  logic         en,
  output logic         wrap
);

  logic [W-1:0] cnt;

  assign wrap = en && !load && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= W'(RST_VAL);
    else if (load)       cnt <= reload;
    else if (en) begin
      if (cnt == '0)     cnt <= reload;
      else               cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int ADIV_W   = 7,
  parameter int SDIV_W   = 15,
  parameter int ADIV_RST = 127,
  parameter int SDIV_RST = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [ADIV_W-1:0] adiv,
  input  logic [SDIV_W-1:0] sdiv,
  output logic              a_pulse,
  output logic              tick
);

  rtc_div_stage #(.W(ADIV_W), .RST_VAL(ADIV_RST)) u_astage (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (hold),
    .reload (adiv),
    .en     (1'b1),
    .wrap   (a_pulse)
  );

  rtc_div_stage #(.W(SDIV_W), .RST_VAL(SDIV_RST)) u_sstage (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (hold),
    .reload (sdiv),
    .en     (a_pulse),
    .wrap   (tick)
  );

endmodule

// File: rtl/rtc_init_ctrl.sv
module rtc_init_ctrl #(
  parameter int INIT_LAT = 2,
  parameter int SYNC_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_wr,
  input  logic req_val,
  input  logic sync_val,
  output logic init_req,
  output logic init_active,
  output logic exit_evt,
  output logic rsf,
  output logic refresh_evt,
  output logic shadow_en
);

  localparam int LW = $clog2(INIT_LAT + 1);
  localparam int SW = $clog2(SYNC_LAT + 1);

  logic [LW-1:0] lat_cnt;
  logic [SW-1:0] sync_cnt;
  logic          sync_clr;

  assign exit_evt    = init_active && !init_req;
  assign sync_clr    = (stat_wr && !sync_val) || exit_evt;
  assign refresh_evt = !rsf && !init_active && !sync_clr && (sync_cnt == SW'(SYNC_LAT - 1));
  assign shadow_en   = refresh_evt || (rsf && !sync_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       init_req <= 1'b0;
    else if (stat_wr) init_req <= req_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_active <= 1'b0;
      lat_cnt     <= '0;
    end else begin
      if (!init_req)                           init_active <= 1'b0;
      else if (lat_cnt == LW'(INIT_LAT - 1))   init_active <= 1'b1;
      if (!init_req || init_active)            lat_cnt <= '0;
      else                                     lat_cnt <= lat_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsf      <= 1'b0;
      sync_cnt <= '0;
    end else begin
      if (sync_clr)         rsf <= 1'b0;
      else if (refresh_evt) rsf <= 1'b1;
      if (sync_clr || rsf || init_active) sync_cnt <= '0;
      else                                sync_cnt <= sync_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
  import rtc_cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             h12,
  input  logic             load_time,
  input  logic             load_date,
  input  logic [REG_W-1:0] wr_data,
  output time_t            time_q,
  output date_t            date_q,
  output logic             day_carry
);

  time_step_t tnext;
  date_t      dnext;

  always_comb begin
    tnext = time_step(time_q, h12);
    dnext = date_step(date_q);
  end

  assign day_carry = tick && tnext.carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         time_q <= RST_TIME;
    else if (load_time) time_q <= word_to_time(wr_data);
    else if (tick)      time_q <= tnext.t;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         date_q <= RST_DATE;
    else if (load_date) date_q <= word_to_date(wr_data);
    else if (day_carry) date_q <= dnext;
  end

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int ADIV_W   = 7,
  parameter int SDIV_W   = 15,
  parameter int ADIV_RST = 127,
  parameter int SDIV_RST = 255,
  parameter int INIT_LAT = 2,
  parameter int SYNC_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic             tick_1hz
);

  logic              init_req, init_active, exit_evt;
  logic              rsf, refresh_evt, shadow_en;
  logic              stat_wr, cfg_ok;
  logic [ADIV_W-1:0] pre_a;
  logic [SDIV_W-1:0] pre_s;
  logic              h12;
  logic              a_pulse, day_carry, inits;
  time_t             time_live;
  date_t             date_live;
  logic [REG_W-1:0]  sh_time, sh_date, pre_word;
  logic [6:0]        live_sec;

  assign stat_wr  = wr_en && (wr_sel == SEL_STAT);
  assign cfg_ok   = wr_en && init_active;
  assign live_sec = time_live.sc;
  assign inits    = (date_live.yr != 8'h00);

  rtc_init_ctrl #(.INIT_LAT(INIT_LAT), .SYNC_LAT(SYNC_LAT)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .stat_wr     (stat_wr),
    .req_val     (wr_data[ST_REQ]),
    .sync_val    (wr_data[ST_SYNC]),
    .init_req    (init_req),
    .init_active (init_active),
    .exit_evt    (exit_evt),
    .rsf         (rsf),
    .refresh_evt (refresh_evt),
    .shadow_en   (shadow_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_a <= ADIV_W'(ADIV_RST);
      pre_s <= SDIV_W'(SDIV_RST);
      h12   <= 1'b0;
    end else if (cfg_ok && (wr_sel == SEL_PRE)) begin
      pre_s <= wr_data[SDIV_W-1:0];
      pre_a <= wr_data[PRE_A_LSB +: ADIV_W];
    end else if (cfg_ok && (wr_sel == SEL_CTRL)) begin
      h12 <= wr_data[CTRL_FMT];
    end
  end

  rtc_prescaler #(
    .ADIV_W(ADIV_W), .SDIV_W(SDIV_W), .ADIV_RST(ADIV_RST), .SDIV_RST(SDIV_RST)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (init_active),
    .adiv    (pre_a),
    .sdiv    (pre_s),
    .a_pulse (a_pulse),
    .tick    (tick_1hz)
  );

  rtc_cal_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_1hz),
    .h12       (h12),
    .load_time (cfg_ok && (wr_sel == SEL_TIME)),
    .load_date (cfg_ok && (wr_sel == SEL_DATE)),
    .wr_data   (wr_data),
    .time_q    (time_live),
    .date_q    (date_live),
    .day_carry (day_carry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_time <= time_to_word(RST_TIME);
      sh_date <= date_to_word(RST_DATE);
    end else if (shadow_en) begin
      sh_time <= time_to_word(time_live);
      sh_date <= date_to_word(date_live);
    end
  end

  always_comb begin
    pre_word = '0;
    pre_word[SDIV_W-1:0] = pre_s;
    pre_word[PRE_A_LSB +: ADIV_W] = pre_a;
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_TIME: rd_data = sh_time;
      SEL_DATE: rd_data = sh_date;
      SEL_CTRL: rd_data[CTRL_FMT] = h12;
      SEL_STAT: begin
        rd_data[ST_REQ]   = init_req;
        rd_data[ST_ACT]   = init_active;
        rd_data[ST_SYNC]  = rsf;
        rd_data[ST_INITS] = inits;
      end
      SEL_PRE:  rd_data = pre_word;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk #(
  parameter int ADIV_W = 7,
  parameter int SDIV_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_req,
  input logic              init_active,
  input logic              rsf,
  input logic              refresh_evt,
  input logic              tick,
  input logic [6:0]        live_sec,
  input logic [ADIV_W-1:0] pre_a,
  input logic [SDIV_W-1:0] pre_s,
  input logic [31:0]       sh_time
);

  assert_init_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_active) |-> $past(init_req));

  assert_init_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (init_active && !init_req) |=> !init_active);

  assert_locked_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !init_active |=> ($stable(pre_a) && $stable(pre_s)));

  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    init_active |-> !tick);

  assert_sec_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && live_sec == 7'h59) |=> (live_sec == 7'h00));

  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsf && !refresh_evt) |=> $stable(sh_time));

  assert_sync_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsf) |-> $past(refresh_evt));

endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk #(.ADIV_W(ADIV_W), .SDIV_W(SDIV_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .init_req    (init_req),
  .init_active (init_active),
  .rsf         (rsf),
  .refresh_evt (refresh_evt),
  .tick        (tick_1hz),
  .live_sec    (live_sec),
  .pre_a       (pre_a),
  .pre_s       (pre_s),
  .sh_time     (sh_time)
);

// File: tb/sim_rtc_bcd_calendar.sv
`timescale 1ns/100ps
module sim_rtc_bcd_calendar;

  typedef struct packed {
    logic        h12;
    logic [31:0] t0;
    logic [31:0] d0;
    logic [31:0] t1;
    logic [31:0] d1;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h00123456, 32'h00246615, 32'h00123457, 32'h00246615},
    '{1'b0, 32'h00235959, 32'h0099F231, 32'h00000000, 32'h00002101},
    '{1'b0, 32'h00235959, 32'h00234228, 32'h00000000, 32'h00236301},
    '{1'b0, 32'h00235959, 32'h00244228, 32'h00000000, 32'h00246229},
    '{1'b0, 32'h00235959, 32'h00248229, 32'h00000000, 32'h0024A301},
    '{1'b0, 32'h00235959, 32'h0025A430, 32'h00000000, 32'h0025C501},
    '{1'b0, 32'h00235959, 32'h00252130, 32'h00000000, 32'h00254131},
    '{1'b0, 32'h00095959, 32'h00252130, 32'h00100000, 32'h00252130},
    '{1'b1, 32'h00115959, 32'h00252310, 32'h00520000, 32'h00252310},
    '{1'b1, 32'h00525959, 32'h00252310, 32'h00410000, 32'h00252310},
    '{1'b1, 32'h00515959, 32'h00252310, 32'h00120000, 32'h00254311},
    '{1'b0, 32'h00005959, 32'h00252130, 32'h00010000, 32'h00252130}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic [2:0]  rd_sel = 3'd0;
  logic [31:0] rd_data;
  logic        tick_1hz;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_bcd_calendar u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .tick_1hz(tick_1hz)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic wait_tick(output int n);
    n = 1;
    while (tick_1hz !== 1'b1 && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic enter_init;
    logic [31:0] s;
    wr(3'd3, 32'h80);
    for (int k = 0; k < 10; k++) begin
      rd(3'd3, s);
      if (s[6]) break;
      @(negedge clk);
    end
  endtask

  function automatic string vec_req(input int i);
    case (i)
      0, 7, 11: return "R6";
      1:        return "R9";
      8, 9, 10: return "R7";
      default:  return "R8";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    int bad;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 time", v, 32'h0);
    rd(3'd1, v); chk("R1 date", v, 32'h00002101);
    rd(3'd4, v); chk("R1 prescaler", v, 32'h007F00FF);
    rd(3'd2, v); chk("R1 control", v, 32'h0);
    rd(3'd3, v); chk("R1 status with R11 year 00", v, 32'h20);

    // R2 init handshake latency
    @(negedge clk);
    rd_sel = 3'd3;
    wr(3'd3, 32'h80);
    chk("R2 active one clock after request", {31'b0, rd_data[6]}, 32'd0);
    @(negedge clk);
    chk("R2 active two clocks after request", {31'b0, rd_data[6]}, 32'd0);
    @(negedge clk);
    chk("R2 active raised", {31'b0, rd_data[6]}, 32'd1);

    wr(3'd4, 32'h00030009);
    wr(3'd2, 32'h0);
    wr(3'd0, 32'h00100000);
    wr(3'd1, 32'h00252130);
    rd(3'd4, v); chk("R3 prescaler written in init", v, 32'h00030009);
    rd(3'd3, v); chk("R11 year nonzero sets bit 4", {31'b0, v[4]}, 32'd1);

    // R4 frozen in init
    bad = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (tick_1hz !== 1'b0) bad++;
    end
    chk("R4 ticks while init active", bad, 0);

    // R5 reload on exit and period
    wr(3'd3, 32'h0);
    wait_tick(n);
    chk("R5 first tick cycle after exit", n, 41);
    @(negedge clk);
    wait_tick(n);
    chk("R5 tick period", n, 40);
    repeat (2) @(negedge clk);
    rd(3'd0, v); chk("R6 time after two ticks", v, 32'h00100002);
    rd(3'd3, v); chk("R2 active low after exit", {31'b0, v[6]}, 32'd0);

    // R3 writes outside init ignored
    wr(3'd0, 32'h00111111);
    wr(3'd1, 32'h00990101);
    wr(3'd4, 32'h00010001);
    wr(3'd2, 32'h40);
    repeat (2) @(negedge clk);
    rd(3'd0, v); chk("R3 time write ignored", v, 32'h00100002);
    rd(3'd1, v); chk("R3 date write ignored", v, 32'h00252130);
    rd(3'd4, v); chk("R3 prescaler write ignored", v, 32'h00030009);
    rd(3'd2, v); chk("R3 control write ignored", v, 32'h0);

    // R10 sync flag cleared by software and restored
    rd_sel = 3'd3;
    wr(3'd3, 32'h20);
    chk("R10 writing one keeps sync", {31'b0, rd_data[5]}, 32'd1);
    wr(3'd3, 32'h0);
    chk("R10 sync cleared", {31'b0, rd_data[5]}, 32'd0);
    @(negedge clk);
    chk("R10 sync still clear", {31'b0, rd_data[5]}, 32'd0);
    @(negedge clk);
    chk("R10 sync restored", {31'b0, rd_data[5]}, 32'd1);

    // rollover table
    for (int i = 0; i < NV; i++) begin
      enter_init();
      wr(3'd2, {25'b0, VECS[i].h12, 6'b0});
      wr(3'd0, VECS[i].t0);
      wr(3'd1, VECS[i].d0);
      wr(3'd3, 32'h0);
      wait_tick(n);
      repeat (4) @(negedge clk);
      rd(3'd0, v); chk($sformatf("%s vector %0d time", vec_req(i), i), v, VECS[i].t1);
      rd(3'd1, v); chk($sformatf("%s vector %0d date", vec_req(i), i), v, VECS[i].d1);
      rd(3'd3, v);
      chk($sformatf("R11 vector %0d year flag", i), {31'b0, v[4]},
          {31'b0, (VECS[i].d1[23:16] != 8'h00)});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule